// File: doc/BRIEF.md
# Read-Only Telemetry Register Target on I2C

This block is an I2C target that answers at one 7-bit bus address and presents a read-only view of a power controller's telemetry registers. It holds a byte-wide register file indexed by an 8-bit command pointer. A host selects a register by writing one command byte. It then issues a repeated START and reads the answer. Two manufacturer-information commands answer with a short fixed block: a length byte followed by the payload. Every other command answers with the single byte stored at that index. Among these are the peak and valley captures for input voltage, output voltage, output current and temperature at 0xC5 to 0xCC.

The bit-level engine lives inside the block. It oversamples SCL and SDA on the system clock, detects START, repeated START and STOP, and shifts bytes. It pulls SDA low through an open-drain enable and never holds SCL low. Write bytes that follow the command byte are acknowledged and then dropped. The pointer falls back to 0xFF whenever a new write phase opens, the host NACKs, or the transaction ends. A side port lets the surrounding logic fill register bytes; the bus cannot change them.

Top module: `telem_i2c_target`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal DEV_ADDR. Bit 0 of the address byte selects a read when it is 1. For any other address it never pulls SDA low until the next START.
- R2: In a write phase, the first byte after the address is acknowledged and becomes the command pointer.
- R3: Write bytes after the first are acknowledged but change neither the register file nor the pointer.
- R4: A read phase opened while the pointer holds 0x99 returns 0x02, 0x52, 0x49 in that order.
- R5: A read phase opened while the pointer holds 0x9A returns 0x02, 0x6C, 0x00 in that order.
- R6: For any other pointer value, a read phase returns the register byte at the pointer. Every byte requested beyond a response's length reads 0xFF, including past the 32-byte response window.
- R7: The pointer becomes 0xFF when a write phase to this target opens, when the host NACKs a read byte, and at STOP ending a transaction to this target.
- R8: After reset every register byte reads 0x00, the pointer is 0xFF and SDA is released.
- R9: START and repeated START restart address reception in any state. A repeated START keeps the pointer, so a write-then-read sequence addresses the written command.
- R10: After a host NACK the block keeps SDA released until the next START or STOP.
- R11: The block changes its SDA drive only while SCL is low and never pulls SDA low during a bit that the host owns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_drive_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| pre_we | input | 1 | Register-file fill strobe |
| pre_addr | input | 8 | Register-file fill index |
| pre_data | input | 8 | Register-file fill byte |

## Verification
The bench builds the block with DEV_ADDR = 0x40 and the default 256-entry register file and 32-byte response window. It drives the bus with eight system clocks per quarter bit. That leaves the two-flop input synchroniser and the edge detectors enough margin for every START, STOP and data bit to land in a well-defined cycle. With the 32-byte window at its default, a single 34-byte read from the manufacturer-ID command crosses the window end. This exercises index saturation next to the short-block padding. Each of the eight peak and valley bytes can be filled distinctly, so reads at both ends of that range are told apart.

// File: rtl/tit_pkg.sv
// Shared types and constants for the telemetry register target.
// Assumes byte-wide registers and an 8-bit command pointer.
package tit_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDAT,
        ST_WACK,
        ST_RDAT,
        ST_RACK,
        ST_WAIT
    } bus_state_t;

    typedef enum logic [1:0] {
        RK_SINGLE,
        RK_ID,
        RK_MODEL
    } resp_kind_t;

    localparam logic [7:0] PTR_IDLE  = 8'hFF;
    localparam logic [7:0] PAD_BYTE  = 8'hFF;
    localparam logic [7:0] BLK_COUNT = 8'h02;
    localparam logic [7:0] ID_B0     = 8'h52;
    localparam logic [7:0] ID_B1     = 8'h49;
    localparam logic [7:0] MODEL_B0  = 8'h6C;
    localparam logic [7:0] MODEL_B1  = 8'h00;

endpackage

// File: rtl/tit_reg_file.sv
// Telemetry register file: one synchronous fill port, one combinational
// read port. Assumes DEPTH is a power of two. Reset clears every entry.
module tit_reg_file #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Clear on reset, otherwise accept fill writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Present the addressed entry.
    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/tit_bus_engine.sv
// Bit-level I2C target engine. Synchronises SCL/SDA into clk and detects
// START, STOP and both SCL edges. It shifts address and data bytes,
// drives ACK and read data through an open-drain enable, and emits
// one-cycle events for the response logic. Assumes clk is at least
// eight times faster than SCL. It never stretches the clock.
module tit_bus_engine
    import tit_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [7:0] tx_byte,
    output logic       sda_drive,
    output logic       scl_s,
    output logic [7:0] rx_byte,
    output logic       ev_wstart,
    output logic       ev_rstart,
    output logic       ev_wbyte,
    output logic       ev_nack,
    output logic       ev_stop,
    output logic       ev_fetch
);

    logic       scl_m, sda_m, sda_s, scl_p, sda_p;
    logic       scl_rise, scl_fall, start_c, stop_c;
    bus_state_t state;
    logic [2:0] bit_cnt;
    logic [7:0] shreg;
    logic       got8, rd_dir, selected, host_ack;

    // Two-flop synchronisers plus one stage of history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {scl_m, scl_s, scl_p} <= 3'b111;
            {sda_m, sda_s, sda_p} <= 3'b111;
        end else begin
            {scl_m, scl_s, scl_p} <= {scl_i, scl_m, scl_s};
            {sda_m, sda_s, sda_p} <= {sda_i, sda_m, sda_s};
        end
    end

    // Bus conditions seen on the synchronised lines.
    always_comb begin
        scl_rise = scl_s && !scl_p;
        scl_fall = !scl_s && scl_p;
        start_c  = scl_s && scl_p && sda_p && !sda_s;
        stop_c   = scl_s && scl_p && !sda_p && sda_s;
    end

    assign rx_byte = shreg;

    // Protocol sequencer: address, ACK, write data, read data, host ACK.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            shreg     <= '0;
            got8      <= 1'b0;
            rd_dir    <= 1'b0;
            selected  <= 1'b0;
            host_ack  <= 1'b0;
            sda_drive <= 1'b0;
            ev_wstart <= 1'b0;
            ev_rstart <= 1'b0;
            ev_wbyte  <= 1'b0;
            ev_nack   <= 1'b0;
            ev_stop   <= 1'b0;
            ev_fetch  <= 1'b0;
        end else begin
            ev_wstart <= 1'b0;
            ev_rstart <= 1'b0;
            ev_wbyte  <= 1'b0;
            ev_nack   <= 1'b0;
            ev_stop   <= 1'b0;
            ev_fetch  <= 1'b0;
            if (start_c) begin
                state     <= ST_ADDR;
                bit_cnt   <= '0;
                got8      <= 1'b0;
                selected  <= 1'b0;
                sda_drive <= 1'b0;
            end else if (stop_c) begin
                ev_stop   <= selected;
                state     <= ST_IDLE;
                selected  <= 1'b0;
                sda_drive <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_WDAT: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[6:0], sda_s};
                            bit_cnt <= bit_cnt + 3'd1;
                            got8    <= (bit_cnt == 3'd7);
                        end else if (scl_fall && got8) begin
                            got8 <= 1'b0;
                            if (state == ST_WDAT) begin
                                sda_drive <= 1'b1;
                                ev_wbyte  <= 1'b1;
                                state     <= ST_WACK;
                            end else if (shreg[7:1] == DEV_ADDR) begin
                                sda_drive <= 1'b1;
                                rd_dir    <= shreg[0];
                                selected  <= 1'b1;
                                ev_rstart <= shreg[0];
                                ev_wstart <= !shreg[0];
                                state     <= ST_AACK;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end
                    end
                    ST_AACK, ST_WACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (state == ST_AACK && rd_dir) begin
                                shreg     <= tx_byte;
                                sda_drive <= !tx_byte[7];
                                ev_fetch  <= 1'b1;
                                state     <= ST_RDAT;
                            end else begin
                                sda_drive <= 1'b0;
                                state     <= ST_WDAT;
                            end
                        end
                    end
                    ST_RDAT: begin
                        if (scl_fall) begin
                            if (bit_cnt == 3'd7) begin
                                sda_drive <= 1'b0;
                                state     <= ST_RACK;
                            end else begin
                                shreg     <= {shreg[6:0], 1'b0};
                                sda_drive <= !shreg[6];
                                bit_cnt   <= bit_cnt + 3'd1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            host_ack <= !sda_s;
                            ev_nack  <= sda_s;
                        end else if (scl_fall) begin
                            bit_cnt <= '0;
                            if (host_ack) begin
                                shreg     <= tx_byte;
                                sda_drive <= !tx_byte[7];
                                ev_fetch  <= 1'b1;
                                state     <= ST_RDAT;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end
                    end
                    default: begin
                        sda_drive <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/tit_resp_unit.sv
// Command pointer and response generator. Loads the pointer from the
// first write byte, resets it on bus events, and at read start captures
// the response kind and the addressed register byte. Serves bytes by
// index, padding with 0xFF. Assumes events arrive as one-cycle pulses.
module tit_resp_unit
    import tit_pkg::*;
#(
    parameter int         BUF_BYTES  = 32,
    parameter logic [7:0] ID_CODE    = 8'h99,
    parameter logic [7:0] MODEL_CODE = 8'h9A,
    localparam int        IW         = $clog2(BUF_BYTES + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_wstart,
    input  logic       ev_rstart,
    input  logic       ev_wbyte,
    input  logic       ev_nack,
    input  logic       ev_stop,
    input  logic       ev_fetch,
    input  logic [7:0] rx_byte,
    input  logic [7:0] rf_data,
    output logic [7:0] ptr,
    output logic [7:0] tx_byte
);

    localparam logic [IW-1:0] IDX_END = IW'(BUF_BYTES);

    logic            first_pending;
    resp_kind_t      kind;
    logic [7:0]      snap;
    logic [IW-1:0]   idx;

    // Pointer: load once per write phase, fall back to idle on bus events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr           <= PTR_IDLE;
            first_pending <= 1'b0;
        end else if (ev_wstart) begin
            ptr           <= PTR_IDLE;
            first_pending <= 1'b1;
        end else if (ev_nack || ev_stop) begin
            ptr           <= PTR_IDLE;
            first_pending <= 1'b0;
        end else if (ev_wbyte && first_pending) begin
            ptr           <= rx_byte;
            first_pending <= 1'b0;
        end
    end

    // Read start: classify the command and capture the register byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind <= RK_SINGLE;
            snap <= '0;
            idx  <= '0;
        end else if (ev_rstart) begin
            kind <= (ptr == ID_CODE)    ? RK_ID :
                    (ptr == MODEL_CODE) ? RK_MODEL : RK_SINGLE;
            snap <= rf_data;
            idx  <= '0;
        end else if (ev_fetch && idx < IDX_END) begin
            idx <= idx + 1'b1;
        end
    end

    // Byte at the current index; everything past the response is padding.
    always_comb begin
        tx_byte = PAD_BYTE;
        if (idx < IDX_END) begin
            unique case (kind)
                RK_ID: begin
                    if (idx == IW'(0))      tx_byte = BLK_COUNT;
                    else if (idx == IW'(1)) tx_byte = ID_B0;
                    else if (idx == IW'(2)) tx_byte = ID_B1;
                end
                RK_MODEL: begin
                    if (idx == IW'(0))      tx_byte = BLK_COUNT;
                    else if (idx == IW'(1)) tx_byte = MODEL_B0;
                    else if (idx == IW'(2)) tx_byte = MODEL_B1;
                end
                default: begin
                    if (idx == IW'(0))      tx_byte = snap;
                end
            endcase
        end
    end

endmodule

// File: rtl/telem_i2c_target.sv
// Read-only telemetry register target on I2C. Connects the bus engine,
// the pointer/response unit and the register file. The fill port is the
// only way to change register contents. Assumes the 8-bit pointer spans
// the whole register file.
module telem_i2c_target
    import tit_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR   = 7'h40,
    parameter int         BUF_BYTES  = 32,
    parameter logic [7:0] ID_CODE    = 8'h99,
    parameter logic [7:0] MODEL_CODE = 8'h9A,
    localparam int        DEPTH      = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_drive_o,
    input  logic       pre_we,
    input  logic [7:0] pre_addr,
    input  logic [7:0] pre_data
);

    logic       scl_s;
    logic [7:0] rx_byte, tx_byte, ptr, rf_rdata;
    logic       ev_wstart, ev_rstart, ev_wbyte, ev_nack, ev_stop, ev_fetch;

    tit_bus_engine #(.DEV_ADDR(DEV_ADDR)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .tx_byte   (tx_byte),
        .sda_drive (sda_drive_o),
        .scl_s     (scl_s),
        .rx_byte   (rx_byte),
        .ev_wstart (ev_wstart),
        .ev_rstart (ev_rstart),
        .ev_wbyte  (ev_wbyte),
        .ev_nack   (ev_nack),
        .ev_stop   (ev_stop),
        .ev_fetch  (ev_fetch)
    );

    tit_resp_unit #(
        .BUF_BYTES  (BUF_BYTES),
        .ID_CODE    (ID_CODE),
        .MODEL_CODE (MODEL_CODE)
    ) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_wstart (ev_wstart),
        .ev_rstart (ev_rstart),
        .ev_wbyte  (ev_wbyte),
        .ev_nack   (ev_nack),
        .ev_stop   (ev_stop),
        .ev_fetch  (ev_fetch),
        .rx_byte   (rx_byte),
        .rf_data   (rf_rdata),
        .ptr       (ptr),
        .tx_byte   (tx_byte)
    );

    tit_reg_file #(.DEPTH(DEPTH), .DATA_W(8)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pre_we),
        .wr_addr (pre_addr),
        .wr_data (pre_data),
        .rd_addr (ptr),
        .rd_data (rf_rdata)
    );

endmodule

// File: rtl/tit_checker.sv
// Protocol and pointer properties for the telemetry target, bound into
// the top module. Assumes the top's internal event and pointer names.
module tit_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       sda_drive,
    input logic [7:0] ptr,
    input logic       ev_wstart,
    input logic       ev_rstart,
    input logic       ev_wbyte,
    input logic       ev_nack,
    input logic       ev_stop
);

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_drive != $past(sda_drive)) |-> !scl_s); // R11

    AST_PTR_IDLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> (ptr == 8'hFF)); // R7

    AST_PTR_IDLE_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        ev_nack |=> (ptr == 8'hFF)); // R7

    AST_PTR_IDLE_WSTART: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wstart |=> (ptr == 8'hFF)); // R7

    AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_nack |=> !sda_drive); // R10

    AST_EVENT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_wstart, ev_rstart, ev_wbyte, ev_nack, ev_stop})); // R9

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!sda_drive && ptr == 8'hFF)); // R8

endmodule

bind telem_i2c_target tit_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_drive (sda_drive_o),
    .ptr       (ptr),
    .ev_wstart (ev_wstart),
    .ev_rstart (ev_rstart),
    .ev_wbyte  (ev_wbyte),
    .ev_nack   (ev_nack),
    .ev_stop   (ev_stop)
);

// File: tb/sim_telem_i2c_target.sv
// Bench: bus master tasks plus a behavioural model (register array,
// pointer, queue of expected read bytes) and a per-clock bus-ownership
// monitor.
module sim_telem_i2c_target;

    localparam int         Q   = 8;
    localparam logic [6:0] OWN = 7'h40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_low = 1'b0;
    logic       pre_we = 1'b0;
    logic [7:0] pre_addr = '0;
    logic [7:0] pre_data = '0;
    wire        sda_drv;
    wire        sda_bus = !(m_low || sda_drv);

    always #10 clk = ~clk;

    telem_i2c_target #(.DEV_ADDR(OWN)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_bus),
        .sda_drive_o (sda_drv),
        .pre_we      (pre_we),
        .pre_addr    (pre_addr),
        .pre_data    (pre_data)
    );

    int         n_chk = 0;
    int         n_fail = 0;
    int         drv_err = 0;
    bit         may_drive = 1'b0;
    logic [7:0] mregs [256];
    logic [7:0] mptr = 8'hFF;
    bit         mfirst = 1'b0;
    bit         msel = 1'b0;
    logic [7:0] expq [$];

    // Every clock: the target must not pull SDA during a host-owned bit (R11).
    always @(negedge clk) begin
        if (rst_n && scl && sda_drv && !may_drive) drv_err++;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=timeout exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic waitq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic m_reset();
        for (int i = 0; i < 256; i++) mregs[i] = 8'h00;
        mptr = 8'hFF; mfirst = 1'b0; msel = 1'b0; expq.delete();
    endtask

    task automatic preload(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        pre_we = 1'b1; pre_addr = a; pre_data = d;
        @(negedge clk);
        pre_we = 1'b0;
        mregs[a] = d;
    endtask

    task automatic bus_start();
        msel = 1'b0;
        m_low = 1'b0; scl = 1'b1; waitq();
        m_low = 1'b1; waitq();
        scl = 1'b0; waitq();
    endtask

    task automatic bus_rstart();
        msel = 1'b0;
        m_low = 1'b0; waitq();
        scl = 1'b1; waitq();
        m_low = 1'b1; waitq();
        scl = 1'b0; waitq();
    endtask

    task automatic bus_stop();
        if (msel) mptr = 8'hFF;
        msel = 1'b0;
        m_low = 1'b1; waitq();
        scl = 1'b1; waitq();
        m_low = 1'b0; waitq();
    endtask

    task automatic write_bit(bit b);
        may_drive = 1'b0;
        m_low = !b; waitq();
        scl = 1'b1; waitq(); waitq();
        scl = 1'b0; waitq();
    endtask

    task automatic read_bit(output bit b);
        m_low = 1'b0; may_drive = 1'b1; waitq();
        scl = 1'b1; waitq();
        b = sda_bus; waitq();
        scl = 1'b0; waitq();
    endtask

    task automatic send_addr(logic [6:0] a, bit rd, output bit ack);
        bit x;
        if (a == OWN) begin
            msel = 1'b1;
            if (rd) begin
                expq.delete();
                if (mptr == 8'h99) begin
                    expq.push_back(8'h02); expq.push_back(8'h52); expq.push_back(8'h49);
                end else if (mptr == 8'h9A) begin
                    expq.push_back(8'h02); expq.push_back(8'h6C); expq.push_back(8'h00);
                end else begin
                    expq.push_back(mregs[mptr]);
                end
            end else begin
                mptr = 8'hFF; mfirst = 1'b1;
            end
        end
        for (int i = 6; i >= 0; i--) write_bit(a[i]);
        write_bit(rd);
        read_bit(x);
        ack = !x;
    endtask

    task automatic send_byte(logic [7:0] b, output bit ack);
        bit x;
        for (int i = 7; i >= 0; i--) write_bit(b[i]);
        read_bit(x);
        ack = !x;
        if (msel && mfirst) begin
            mptr = b; mfirst = 1'b0;
        end
    endtask

    task automatic recv_byte(bit give_ack, output logic [7:0] v);
        bit x;
        for (int i = 7; i >= 0; i--) begin
            read_bit(x);
            v[i] = x;
        end
        write_bit(!give_ack);
        if (!give_ack) mptr = 8'hFF;
    endtask

    function automatic logic [7:0] pop_exp();
        if (expq.size() == 0) return 8'hFF;
        return expq.pop_front();
    endfunction

    // Write one command byte, repeated START, read n bytes, STOP.
    task automatic cmd_read(logic [7:0] cmd, int n, string tag);
        bit ack;
        logic [7:0] v;
        bus_start();
        send_addr(OWN, 1'b0, ack); chk({tag, " R1 addr-w ack"}, ack, 1);
        send_byte(cmd, ack);       chk({tag, " R2 cmd ack"}, ack, 1);
        bus_rstart();
        send_addr(OWN, 1'b1, ack); chk({tag, " R9 addr-r ack"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, v);
            chk({tag, " data"}, v, pop_exp());
        end
        bus_stop();
    endtask

    initial begin
        bit ack;
        logic [7:0] v;
        m_reset();
        repeat (5) @(negedge clk);
        chk("R8 sda released in reset", sda_drv, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R8: register file clear after reset
        cmd_read(8'h20, 1, "R8 cleared reg");

        preload(8'h10, 8'hA5);
        preload(8'hC5, 8'h3C);
        preload(8'hCC, 8'h81);
        preload(8'hFF, 8'h5E);

        // R1: foreign address is not acknowledged
        bus_start();
        send_addr(7'h23, 1'b0, ack);
        chk("R1 foreign addr nack", ack, 0);
        bus_stop();

        // R6: single byte then padding
        cmd_read(8'h10, 2, "R6 single");
        cmd_read(8'hC5, 1, "R6 peak");
        cmd_read(8'hCC, 1, "R6 valley");
        // R4, R5: fixed blocks
        cmd_read(8'h99, 4, "R4 id");
        cmd_read(8'h9A, 3, "R5 model");

        // R3: extra write bytes are acknowledged and discarded
        bus_start();
        send_addr(OWN, 1'b0, ack); chk("R3 addr ack", ack, 1);
        send_byte(8'h10, ack);     chk("R3 cmd ack", ack, 1);
        send_byte(8'h77, ack);     chk("R3 extra ack", ack, 1);
        send_byte(8'h88, ack);     chk("R3 extra ack 2", ack, 1);
        bus_stop();
        cmd_read(8'h10, 1, "R3 reg kept");
        cmd_read(8'h11, 1, "R3 neighbour kept");

        // R7: after STOP the pointer is idle, so a bare read hits 0xFF
        bus_start();
        send_addr(OWN, 1'b1, ack); chk("R7 addr ack", ack, 1);
        recv_byte(1'b0, v);        chk("R7 read after stop", v, pop_exp());
        bus_stop();

        // R7, R10: NACK resets the pointer; next read via repeated START
        bus_start();
        send_addr(OWN, 1'b0, ack);
        send_byte(8'hC5, ack);
        bus_rstart();
        send_addr(OWN, 1'b1, ack);
        recv_byte(1'b0, v);        chk("R10 first read", v, pop_exp());
        bus_rstart();
        send_addr(OWN, 1'b1, ack); chk("R9 addr after nack", ack, 1);
        recv_byte(1'b0, v);        chk("R7 read after nack", v, pop_exp());
        bus_stop();

        // R7: a new write phase resets the pointer
        bus_start();
        send_addr(OWN, 1'b0, ack);
        send_byte(8'h10, ack);
        bus_rstart();
        send_addr(OWN, 1'b0, ack); chk("R7 second write addr", ack, 1);
        bus_rstart();
        send_addr(OWN, 1'b1, ack);
        recv_byte(1'b0, v);        chk("R7 read after write start", v, pop_exp());
        bus_stop();

        // R6: long read across the 32-byte window
        cmd_read(8'h99, 34, "R6 long");

        chk("R11 no drive in host bits", drv_err, 0);

        // R8: mid-run reset clears contents
        @(negedge clk); rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8 sda released mid reset", sda_drv, 0);
        rst_n = 1'b1;
        m_reset();
        repeat (4) @(negedge clk);
        cmd_read(8'h10, 1, "R8 after reset");

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule